// File: doc/BRIEF.md
# Table-Driven Configuration Stepper Pair

This block holds two independent configuration steppers. Each one walks a device sub-block through a set of stored configurations. Every stepper keeps two tables. The first holds configuration words ("modes"). The second is an ordering table that says which mode each numbered step ("state") uses. A state pointer selects the current step. State 0 is a fixed home position that always uses mode 0. States 1 to the programmed depth form the active loop. An advance event moves the pointer one step forward, and a home event sends it back to state 0.

Events come from asynchronous pins, which are synchronized and edge-detected, or from a single-cycle control write that can address both steppers at once. A final output stage drives the selected word. That stage either follows the active word on every cycle, or, in latched style, updates only on the trailing edge of an event pulse, so that a whole step changes the outputs at one instant. When a stepper is switched off, its output takes a host-written manual word instead. That word still passes through the same final stage.

Top module: `modeseq_pair`

## Requirements
- R1: A host write with `wr_kind` 0 stores `wr_data` into mode-table entry `wr_idx` (0..MODES-1). Kind 1 stores `wr_data[MIDX_W-1:0]` as the mode index of state `wr_idx` (1..STATES). Kind 2 stores the manual word. Kind 3 and out-of-range indices change nothing. Each write goes to stepper `wr_seq` only.
- R2: After reset, every stepper reports state 0 and mode 0 and drives an output word of 0.
- R3: State 0 always maps to mode 0. A kind-1 write with index 0 is ignored.
- R4: An advance moves the pointer to state 1 when it is at state 0 or at or beyond the effective depth. Otherwise the pointer goes to the next state. The effective depth is min(depth, STATES). With an effective depth of 0, an advance leaves the pointer where it is.
- R5: A home event returns the pointer to state 0. If advance and home arrive in the same cycle, home wins.
- R6: Events come from a rising edge on `adv_pin`/`rst_pin` after a two-flop synchronizer, or from `ctl_wr` with the per-stepper bits of `ctl_adv`/`ctl_rst`. Each stepper responds only to its own bits, and both can move in the same cycle.
- R7: With latching off and the stepper on, `cfg_out` equals the mode-table word of the current state's mode, one cycle after the pointer changes.
- R8: With latching on, `cfg_out` changes only in the cycle after a trailing edge: a falling edge of either pin, or the cycle that follows a control write addressing the stepper. The pointer itself moves on the leading edge.
- R9: With the stepper off, advance and home events do not move the pointer. With latching off, `cfg_out` follows the manual word.
- R10: With the stepper off and latching on, a new manual word reaches `cfg_out` only after a pulse's trailing edge.
- R11: `state_idx` reports the pointer and `mode_idx` reports the mode index that the current state maps to.
- R12: The pointer never exceeds STATES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_en | input | NUM_SEQ | Per-stepper enable (0 selects manual word) |
| latch_en | input | NUM_SEQ | Per-stepper latched output style |
| depth | input | NUM_SEQ x SIDX_W | Number of states in the loop, home excluded |
| wr_en | input | 1 | Host table write strobe |
| wr_seq | input | SEL_W | Target stepper of a host write |
| wr_kind | input | 2 | 0 mode table, 1 state table, 2 manual word, 3 none |
| wr_idx | input | IDX_W | Table index of a host write |
| wr_data | input | MODE_W | Write data |
| ctl_wr | input | 1 | Control-write strobe for events |
| ctl_adv | input | NUM_SEQ | Advance request per stepper with `ctl_wr` |
| ctl_rst | input | NUM_SEQ | Home request per stepper with `ctl_wr` |
| adv_pin | input | NUM_SEQ | Asynchronous advance pins |
| rst_pin | input | NUM_SEQ | Asynchronous home pins |
| cfg_out | output | NUM_SEQ x MODE_W | Driven configuration word |
| state_idx | output | NUM_SEQ x SIDX_W | Current state pointer |
| mode_idx | output | NUM_SEQ x MIDX_W | Mode index of the current state |

## Verification
The bench builds two steppers with MODES=4 and STATES=5. The 3-bit depth field can therefore also carry 6 and 7, which lets a sweep over every depth reach the clamp to STATES as well as the wrap, depth-0 and home cases, with both steppers advanced together. The small tables make it cheap to program every entry with an arithmetic pattern and to predict each output word. Separate passes cover pin events, the advance-versus-home conflict, the latched style and the manual path.

// File: rtl/modeseq_pkg.sv
package modeseq_pkg;
    typedef enum logic [1:0] {
        WK_MODE   = 2'd0,
        WK_STATE  = 2'd1,
        WK_MANUAL = 2'd2,
        WK_NONE   = 2'd3
    } wr_kind_e;
endpackage

// File: rtl/modeseq_pin_sync.sv
module modeseq_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.s1   = pin;
        nxt_d.s2   = cur_q.s1;
        nxt_d.prev = cur_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rise = cur_q.s2 & ~cur_q.prev;
    assign fall = ~cur_q.s2 & cur_q.prev;
endmodule

// File: rtl/modeseq_core.sv
module modeseq_core
    import modeseq_pkg::*;
#(
    parameter int MODES  = 8,
    parameter int STATES = 8,
    parameter int MODE_W = 8,
    parameter int SIDX_W = 4,
    parameter int MIDX_W = 3,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              latch_en,
    input  logic [SIDX_W-1:0] depth,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [MODE_W-1:0] wr_data,
    input  logic              adv,
    input  logic              home,
    input  logic              fall,
    output logic [MODE_W-1:0] out_word,
    output logic [SIDX_W-1:0] state_idx,
    output logic [MIDX_W-1:0] mode_idx
);
    localparam logic [SIDX_W-1:0] LAST_STATE = SIDX_W'(STATES);

    typedef struct packed {
        logic [MODES-1:0][MODE_W-1:0]  mtab;
        logic [STATES-1:0][MIDX_W-1:0] stab;
        logic [MODE_W-1:0]             manual;
        logic [SIDX_W-1:0]             ptr;
        logic [MODE_W-1:0]             out;
    } core_t;

    core_t             cur_q, nxt_d;
    logic [SIDX_W-1:0] depth_eff;
    logic [MIDX_W-1:0] cur_mode;
    logic [MODE_W-1:0] seq_word;
    logic [MODE_W-1:0] src_word;
    wr_kind_e          kind;

    assign kind = wr_kind_e'(wr_kind);

    always_comb begin
        depth_eff = (depth > LAST_STATE) ? LAST_STATE : depth;

        cur_mode = '0;
        for (int k = 0; k < STATES; k++) begin
            if (32'(cur_q.ptr) == k + 1) cur_mode = cur_q.stab[k];
        end

        seq_word = '0;
        for (int m = 0; m < MODES; m++) begin
            if (32'(cur_mode) == m) seq_word = cur_q.mtab[m];
        end

        src_word = en ? seq_word : cur_q.manual;

        nxt_d = cur_q;

        if (wr_en) begin
            unique case (kind)
                WK_MODE: begin
                    for (int m = 0; m < MODES; m++) begin
                        if (32'(wr_idx) == m) nxt_d.mtab[m] = wr_data;
                    end
                end
                WK_STATE: begin
                    for (int k = 0; k < STATES; k++) begin
                        if (32'(wr_idx) == k + 1) nxt_d.stab[k] = wr_data[MIDX_W-1:0];
                    end
                end
                WK_MANUAL: nxt_d.manual = wr_data;
                default: ;
            endcase
        end

        if (en) begin
            if (home) begin
                nxt_d.ptr = '0;
            end else if (adv && depth_eff != '0) begin
                if (cur_q.ptr == '0 || cur_q.ptr >= depth_eff) nxt_d.ptr = SIDX_W'(1);
                else                                            nxt_d.ptr = cur_q.ptr + 1'b1;
            end
        end

        if (!latch_en || fall) nxt_d.out = src_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign out_word  = cur_q.out;
    assign state_idx = cur_q.ptr;
    assign mode_idx  = cur_mode;
endmodule

// File: rtl/modeseq_pair.sv
module modeseq_pair
    import modeseq_pkg::*;
#(
    parameter int NUM_SEQ = 2,
    parameter int MODES   = 8,
    parameter int STATES  = 8,
    parameter int MODE_W  = 8,
    parameter int SIDX_W  = $clog2(STATES + 1),
    parameter int MIDX_W  = (MODES > 1) ? $clog2(MODES) : 1,
    parameter int IDX_W   = (SIDX_W > MIDX_W) ? SIDX_W : MIDX_W,
    parameter int SEL_W   = (NUM_SEQ > 1) ? $clog2(NUM_SEQ) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_SEQ-1:0]               seq_en,
    input  logic [NUM_SEQ-1:0]               latch_en,
    input  logic [NUM_SEQ-1:0][SIDX_W-1:0]   depth,
    input  logic                             wr_en,
    input  logic [SEL_W-1:0]                 wr_seq,
    input  logic [1:0]                       wr_kind,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [MODE_W-1:0]                wr_data,
    input  logic                             ctl_wr,
    input  logic [NUM_SEQ-1:0]               ctl_adv,
    input  logic [NUM_SEQ-1:0]               ctl_rst,
    input  logic [NUM_SEQ-1:0]               adv_pin,
    input  logic [NUM_SEQ-1:0]               rst_pin,
    output logic [NUM_SEQ-1:0][MODE_W-1:0]   cfg_out,
    output logic [NUM_SEQ-1:0][SIDX_W-1:0]   state_idx,
    output logic [NUM_SEQ-1:0][MIDX_W-1:0]   mode_idx
);
    typedef struct packed {
        logic [NUM_SEQ-1:0] cfall;
    } ctl_t;

    ctl_t               ctl_q, ctl_d;
    logic [NUM_SEQ-1:0] adv_rise, adv_fall, rst_rise, rst_fall;
    logic [NUM_SEQ-1:0] adv_ev, home_ev, fall_ev;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.cfall = ctl_wr ? (ctl_adv | ctl_rst) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    for (genvar g = 0; g < NUM_SEQ; g++) begin : g_seq
        modeseq_pin_sync u_adv_sync (
            .clk(clk), .rst_n(rst_n), .pin(adv_pin[g]),
            .rise(adv_rise[g]), .fall(adv_fall[g])
        );
        modeseq_pin_sync u_rst_sync (
            .clk(clk), .rst_n(rst_n), .pin(rst_pin[g]),
            .rise(rst_rise[g]), .fall(rst_fall[g])
        );

        assign adv_ev[g]  = adv_rise[g] | (ctl_wr & ctl_adv[g]);
        assign home_ev[g] = rst_rise[g] | (ctl_wr & ctl_rst[g]);
        assign fall_ev[g] = adv_fall[g] | rst_fall[g] | ctl_q.cfall[g];

        modeseq_core #(
            .MODES(MODES), .STATES(STATES), .MODE_W(MODE_W),
            .SIDX_W(SIDX_W), .MIDX_W(MIDX_W), .IDX_W(IDX_W)
        ) u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (seq_en[g]),
            .latch_en (latch_en[g]),
            .depth    (depth[g]),
            .wr_en    (wr_en && (32'(wr_seq) == g)),
            .wr_kind  (wr_kind),
            .wr_idx   (wr_idx),
            .wr_data  (wr_data),
            .adv      (adv_ev[g]),
            .home     (home_ev[g]),
            .fall     (fall_ev[g]),
            .out_word (cfg_out[g]),
            .state_idx(state_idx[g]),
            .mode_idx (mode_idx[g])
        );
    end
endmodule

// File: rtl/modeseq_chk.sv
module modeseq_chk #(
    parameter int NUM_SEQ = 2,
    parameter int STATES  = 8,
    parameter int MODE_W  = 8,
    parameter int SIDX_W  = 4,
    parameter int MIDX_W  = 3
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_SEQ-1:0]             seq_en,
    input logic [NUM_SEQ-1:0]             latch_en,
    input logic [NUM_SEQ-1:0][MODE_W-1:0] cfg_out,
    input logic [NUM_SEQ-1:0][SIDX_W-1:0] state_idx,
    input logic [NUM_SEQ-1:0][MIDX_W-1:0] mode_idx,
    input logic [NUM_SEQ-1:0]             fall_ev
);
    for (genvar g = 0; g < NUM_SEQ; g++) begin : g_chk
        // R3
        home_mode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            state_idx[g] == '0 |-> mode_idx[g] == '0);

        // R12
        ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            32'(state_idx[g]) <= STATES);

        // R9
        frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !seq_en[g] |=> $stable(state_idx[g]));

        // R4
        single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(state_idx[g]) |->
                (state_idx[g] <= SIDX_W'(1) || state_idx[g] == $past(state_idx[g]) + 1'b1));

        // R8
        latched_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(latch_en[g]) && cfg_out[g] != $past(cfg_out[g])) |-> $past(fall_ev[g]));
    end
endmodule

bind modeseq_pair modeseq_chk #(
    .NUM_SEQ(NUM_SEQ), .STATES(STATES), .MODE_W(MODE_W),
    .SIDX_W(SIDX_W), .MIDX_W(MIDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .latch_en(latch_en),
    .cfg_out(cfg_out), .state_idx(state_idx), .mode_idx(mode_idx),
    .fall_ev(fall_ev)
);

// File: tb/sim_modeseq_pair.sv
`timescale 1ns/1ps
module sim_modeseq_pair;
    localparam int N      = 2;
    localparam int MODES  = 4;
    localparam int STATES = 5;
    localparam int MODE_W = 8;
    localparam int SIDX_W = $clog2(STATES + 1);
    localparam int MIDX_W = $clog2(MODES);
    localparam int IDX_W  = (SIDX_W > MIDX_W) ? SIDX_W : MIDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] seq_en = '0, latch_en = '0;
    logic [N-1:0][SIDX_W-1:0] depth = '0;
    logic wr_en = 1'b0;
    logic [0:0] wr_seq = '0;
    logic [1:0] wr_kind = 2'd3;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [MODE_W-1:0] wr_data = '0;
    logic ctl_wr = 1'b0;
    logic [N-1:0] ctl_adv = '0, ctl_rst = '0, adv_pin = '0, rst_pin = '0;
    logic [N-1:0][MODE_W-1:0] cfg_out;
    logic [N-1:0][SIDX_W-1:0] state_idx;
    logic [N-1:0][MIDX_W-1:0] mode_idx;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    int exp_ptr [N];

    always #2.5 clk = ~clk;

    modeseq_pair #(.NUM_SEQ(N), .MODES(MODES), .STATES(STATES), .MODE_W(MODE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .latch_en(latch_en), .depth(depth),
        .wr_en(wr_en), .wr_seq(wr_seq), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
        .ctl_wr(ctl_wr), .ctl_adv(ctl_adv), .ctl_rst(ctl_rst), .adv_pin(adv_pin),
        .rst_pin(rst_pin), .cfg_out(cfg_out), .state_idx(state_idx), .mode_idx(mode_idx)
    );

    function automatic int mword(int s, int m);
        return (8'h11 + s * 8'h40 + m * 8'h0D) % 256;
    endfunction
    function automatic int smap(int s, int k);
        return (k == 0) ? 0 : (k * 3 + s + 1) % MODES;
    endfunction
    function automatic int nxt(int p, int d);
        int de;
        de = (d > STATES) ? STATES : d;
        if (de == 0) return p;
        if (p == 0 || p >= de) return 1;
        return p + 1;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic wr(int s, int kind, int idx, int data);
        wr_en = 1'b1; wr_seq = 1'(s); wr_kind = 2'(kind);
        wr_idx = IDX_W'(idx); wr_data = MODE_W'(data);
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic ctl(logic [N-1:0] a, logic [N-1:0] r);
        ctl_wr = 1'b1; ctl_adv = a; ctl_rst = r;
        tick(1);
        ctl_wr = 1'b0; ctl_adv = '0; ctl_rst = '0;
        tick(3);
    endtask

    task automatic check_seq(int s, string req);
        chk({req, " state"}, int'(state_idx[s]), exp_ptr[s]);
        chk({req, " mode"},  int'(mode_idx[s]),  smap(s, exp_ptr[s]));
        chk({req, " word"},  int'(cfg_out[s]),   mword(s, smap(s, exp_ptr[s])));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int w;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R2 reset state
        for (int s = 0; s < N; s++) begin
            chk("R2 state", int'(state_idx[s]), 0);
            chk("R2 mode", int'(mode_idx[s]), 0);
            chk("R2 word", int'(cfg_out[s]), 0);
        end

        // R1 program tables; R3 index-0 state write and kind 3 ignored
        for (int s = 0; s < N; s++) begin
            for (int m = 0; m < MODES; m++) wr(s, 0, m, mword(s, m));
            for (int k = 1; k <= STATES; k++) wr(s, 1, k, smap(s, k));
            wr(s, 1, 0, 3);
            wr(s, 3, 1, 2);
            wr(s, 2, 0, 8'hA5 ^ s);
        end

        depth[0] = SIDX_W'(STATES); depth[1] = SIDX_W'(STATES);
        seq_en = '1;
        tick(3);
        for (int s = 0; s < N; s++) begin
            exp_ptr[s] = 0;
            check_seq(s, "R3 home");
        end

        // R4 R6 R7 R11 depth sweep, both steppers together
        for (int d = 0; d < 8; d++) begin
            depth[0] = SIDX_W'(d); depth[1] = SIDX_W'(d);
            ctl('0, '1);
            for (int s = 0; s < N; s++) begin
                exp_ptr[s] = 0;
                check_seq(s, "R5 ctl home");
            end
            for (int a = 0; a < 13; a++) begin
                ctl('1, '0);
                for (int s = 0; s < N; s++) begin
                    exp_ptr[s] = nxt(exp_ptr[s], d);
                    check_seq(s, "R4 R7 R11 advance");
                end
            end
        end

        // R6 pin advance on stepper 0 only
        depth[0] = 3'd5; depth[1] = 3'd5;
        ctl('0, '1);
        exp_ptr[0] = 0; exp_ptr[1] = 0;
        for (int a = 0; a < 3; a++) begin
            adv_pin[0] = 1'b1; tick(4);
            adv_pin[0] = 1'b0; tick(4);
            exp_ptr[0] = nxt(exp_ptr[0], 5);
            check_seq(0, "R6 pin advance");
            check_seq(1, "R6 other stepper idle");
        end

        // R5 home wins over advance (control write and pins)
        ctl(2'b10, '0);
        exp_ptr[1] = 1;
        ctl(2'b10, 2'b10);
        exp_ptr[1] = 0;
        check_seq(1, "R5 ctl priority");
        adv_pin[0] = 1'b1; rst_pin[0] = 1'b1; tick(4);
        adv_pin[0] = 1'b0; rst_pin[0] = 1'b0; tick(4);
        exp_ptr[0] = 0;
        check_seq(0, "R5 pin priority");

        // R8 latched style on stepper 0
        latch_en[0] = 1'b1;
        tick(2);
        adv_pin[0] = 1'b1; tick(5);
        chk("R8 pointer on leading edge", int'(state_idx[0]), 1);
        chk("R8 word held", int'(cfg_out[0]), mword(0, 0));
        adv_pin[0] = 1'b0; tick(5);
        exp_ptr[0] = 1;
        check_seq(0, "R8 after trailing edge");
        ctl(2'b01, '0);
        exp_ptr[0] = 2;
        check_seq(0, "R8 ctl write");

        // R9 stepper 1 off, latch off: manual word, pulses ignored
        seq_en[1] = 1'b0;
        tick(3);
        chk("R9 manual word", int'(cfg_out[1]), 8'hA5 ^ 1);
        ctl(2'b10, '0);
        chk("R9 advance ignored", int'(state_idx[1]), 0);
        ctl('0, '0);
        wr(1, 0, 0, 8'hEE);
        tick(3);
        chk("R9 table write while off", int'(cfg_out[1]), 8'hA5 ^ 1);

        // R10 stepper 0 off with latching on
        w = int'(cfg_out[0]);
        seq_en[0] = 1'b0;
        wr(0, 2, 0, 8'h3C);
        tick(4);
        chk("R10 manual held", int'(cfg_out[0]), w);
        adv_pin[0] = 1'b1; tick(4);
        adv_pin[0] = 1'b0; tick(5);
        chk("R10 manual after pulse", int'(cfg_out[0]), 8'h3C);
        chk("R9 pin ignored while off", int'(state_idx[0]), 2);

        // R1 out-of-range mode index and bad index writes left tables intact
        seq_en[0] = 1'b1; latch_en[0] = 1'b0;
        wr(0, 0, 7, 8'hFF);
        ctl('0, 2'b01);
        exp_ptr[0] = 0;
        for (int a = 0; a < 5; a++) begin
            ctl(2'b01, '0);
            exp_ptr[0] = nxt(exp_ptr[0], 5);
            check_seq(0, "R1 tables intact");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule